// File: doc/BRIEF.md
# Bus Address Decoder with Boot Remap and Abort Capture

This block takes address-phase requests from two bus masters, a CPU and a peripheral DMA engine, and forwards one request at a time to a slave port. The slave port carries a one-hot select. The CPU always wins when both masters request. Each address is decoded into one of three 1 MB internal memory areas or one 256 MB peripheral area. Area 0 is the boot area. A remap control bit chooses whether flash or SRAM answers there, so software can move the exception vectors into writable memory while it runs.

Every access is also checked against its size for alignment. A request that is misaligned, or that falls outside all decoded areas, never reaches a slave. It is consumed at once with an abort flag back to the master that issued it. The first such abort is recorded with its address, size, direction, master and cause. The record stays until software reads it. Any abort that arrives while the record is still held sets an overrun flag.

Requests use valid/ready. A master holds its valid and request fields stable until it sees its ready. The slave back-pressures a good request by holding `slv_ready` low. An aborted request is accepted without waiting for the slave. There is no data phase here: data moves directly between masters and slaves.

Top module: `bus_addr_decoder`

## Requirements
- R1: Decoding works on the upper address bits, and `slv_sel` is one-hot whenever `slv_valid` is high.
  - Bits [31:20] = 0x001 select flash (`slv_sel` bit 0).
  - Bits [31:20] = 0x002 select SRAM (bit 1).
  - Bits [31:28] = 0xF select the peripheral area (bit 2).
- R2: Bits [31:20] = 0x000 form the boot area. It selects flash while `remap_on` is 0 and SRAM while `remap_on` is 1.
- R3: `remap_on` inverts on every rising clock edge at which `remap_cmd` is high.
- R4: The alignment rule depends on the size code.
  - Size 0 (byte) is never misaligned.
  - Size 1 (halfword) needs address bit 0 clear.
  - Size 2 or 3 (word) needs bits 1:0 clear.
- R5: An address outside every area aborts with cause 2 (undefined). This cause takes precedence over misalignment. A misaligned access to a decoded area aborts with cause 1.
- R6: In the cycle a request aborts, the issuing master sees its ready and its abort flag high, and `slv_valid` stays low.
- R7: The CPU has fixed priority. While `cpu_valid` is high, `dma_ready` and `dma_abort` stay low. `slv_master` reads 0 for the CPU and 1 for the DMA.
- R8: A good request drives `slv_valid` high with its address, size and direction forwarded, in the same cycle. The granted master's ready follows `slv_ready`.
- R9: The first abort after the status is empty is captured at the clock edge. The status holds its address, size, direction, master and cause, and `stat_valid` goes high. All of these hold until a `stat_rd` pulse.
- R10: Overrun and clearing follow these rules.
  - An abort while the status is held (and no read is in the same cycle) sets `stat_overrun` and leaves the captured fields unchanged.
  - A read alone clears `stat_valid` and `stat_overrun`.
  - A read and an abort in the same cycle capture the new abort, with overrun clear.
- R11: After reset, `remap_on`, `stat_valid` and `stat_overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | CPU request accepted |
| cpu_addr | input | 32 | CPU address |
| cpu_size | input | 2 | CPU size: 0 byte, 1 half, 2/3 word |
| cpu_write | input | 1 | CPU direction, 1 = write |
| cpu_abort | output | 1 | CPU request aborted (with ready) |
| dma_valid | input | 1 | DMA request valid |
| dma_ready | output | 1 | DMA request accepted |
| dma_addr | input | 32 | DMA address |
| dma_size | input | 2 | DMA size |
| dma_write | input | 1 | DMA direction |
| dma_abort | output | 1 | DMA request aborted (with ready) |
| slv_valid | output | 1 | Forwarded request valid |
| slv_ready | input | 1 | Selected slave accepts |
| slv_sel | output | 3 | One-hot: flash, SRAM, peripheral |
| slv_addr | output | 32 | Forwarded address |
| slv_size | output | 2 | Forwarded size |
| slv_write | output | 1 | Forwarded direction |
| slv_master | output | 1 | Granted master, 0 CPU, 1 DMA |
| remap_cmd | input | 1 | Remap toggle command |
| remap_on | output | 1 | Current remap state |
| stat_rd | input | 1 | Status read, clears the record |
| stat_valid | output | 1 | An abort record is held |
| stat_addr | output | 32 | Captured abort address |
| stat_size | output | 2 | Captured size |
| stat_write | output | 1 | Captured direction |
| stat_master | output | 1 | Captured master |
| stat_cause | output | 2 | Captured cause: 1 misaligned, 2 undefined |
| stat_overrun | output | 1 | Further abort while record held |

## Verification
The decoder is driven with addresses in each area and with one unmapped address. The boot address is tried with remap off, toggled on and toggled back off, which shows whether the remap redirects only the boot area. Aligned and misaligned pairs are applied at each size to separate the per-size alignment rules. An address that is both unmapped and odd shows which abort cause wins. Overlapping CPU and DMA requests show the priority and stall, and a held slave ready shows the back-pressure. Finally, a sequence of capture, a second abort, a read, and a read coinciding with an abort separates first-wins capture, overrun and clearing.

// File: rtl/bad_pkg.sv
package bad_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_MISALIGN = 2'd1,
    CAUSE_UNDEF    = 2'd2
  } ab_cause_e;

  localparam int SEL_FLASH  = 0;
  localparam int SEL_SRAM   = 1;
  localparam int SEL_PERIPH = 2;
  localparam int N_SLV      = 3;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
endpackage

// File: rtl/bad_arbiter.sv
module bad_arbiter #(
  parameter int N_MST = 2,
  localparam int MID_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req,
  output logic [N_MST-1:0] gnt,
  output logic [MID_W-1:0] gnt_id
);
  logic found;

  // lowest index wins
  always_comb begin
    gnt    = '0;
    gnt_id = '0;
    found  = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        gnt_id = MID_W'(i);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bad_decode.sv
module bad_decode
  import bad_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int AREA_BITS   = 20,
  parameter int PERIPH_BITS = 28,
  localparam int HI_W = ADDR_W - AREA_BITS,
  localparam int PT_W = ADDR_W - PERIPH_BITS,
  parameter logic [PT_W-1:0] PERIPH_TAG = '1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              remap,
  output logic [N_SLV-1:0]  sel,
  output ab_cause_e         cause
);
  logic [HI_W-1:0] hi;
  logic            misal;
  logic [N_SLV-1:0] raw;

  assign hi = addr[ADDR_W-1:AREA_BITS];

  always_comb begin
    raw = '0;
    if (addr[ADDR_W-1:PERIPH_BITS] == PERIPH_TAG) raw[SEL_PERIPH] = 1'b1;
    else if (hi == HI_W'(0)) begin
      if (remap) raw[SEL_SRAM] = 1'b1;
      else       raw[SEL_FLASH] = 1'b1;
    end
    else if (hi == HI_W'(1)) raw[SEL_FLASH] = 1'b1;
    else if (hi == HI_W'(2)) raw[SEL_SRAM]  = 1'b1;
  end

  always_comb begin
    case (size)
      SZ_BYTE: misal = 1'b0;
      SZ_HALF: misal = addr[0];
      default: misal = |addr[1:0];
    endcase
  end

  always_comb begin
    sel   = raw;
    cause = CAUSE_NONE;
    if (raw == '0) cause = CAUSE_UNDEF;
    else if (misal) begin
      cause = CAUSE_MISALIGN;
      sel   = '0;
    end
  end
endmodule

// File: rtl/bad_abort_status.sv
module bad_abort_status #(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ab_evt,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [1:0]        ev_size,
  input  logic              ev_write,
  input  logic [MID_W-1:0]  ev_mid,
  input  logic [1:0]        ev_cause,
  input  logic              rd_clr,
  output logic              st_valid,
  output logic [ADDR_W-1:0] st_addr,
  output logic [1:0]        st_size,
  output logic              st_write,
  output logic [MID_W-1:0]  st_mid,
  output logic [1:0]        st_cause,
  output logic              st_overrun
);
  logic held;
  assign held = st_valid && !rd_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_valid   <= 1'b0;
      st_overrun <= 1'b0;
      st_addr    <= '0;
      st_size    <= '0;
      st_write   <= 1'b0;
      st_mid     <= '0;
      st_cause   <= '0;
    end else if (ab_evt && !held) begin
      st_valid   <= 1'b1;
      st_overrun <= 1'b0;
      st_addr    <= ev_addr;
      st_size    <= ev_size;
      st_write   <= ev_write;
      st_mid     <= ev_mid;
      st_cause   <= ev_cause;
    end else if (ab_evt) begin
      st_overrun <= 1'b1;
    end else if (rd_clr) begin
      st_valid   <= 1'b0;
      st_overrun <= 1'b0;
    end
  end

  AST_RECORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> st_valid && $stable(st_addr) && $stable(st_cause)); // R9
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    held && ab_evt |=> st_overrun); // R10
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !ab_evt |=> !st_valid && !st_overrun); // R10
endmodule

// File: rtl/bus_addr_decoder.sv
module bus_addr_decoder
  import bad_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int AREA_BITS   = 20,
  parameter int PERIPH_BITS = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_write,
  output logic              cpu_abort,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [1:0]        dma_size,
  input  logic              dma_write,
  output logic              dma_abort,
  output logic              slv_valid,
  input  logic              slv_ready,
  output logic [2:0]        slv_sel,
  output logic [ADDR_W-1:0] slv_addr,
  output logic [1:0]        slv_size,
  output logic              slv_write,
  output logic              slv_master,
  input  logic              remap_cmd,
  output logic              remap_on,
  input  logic              stat_rd,
  output logic              stat_valid,
  output logic [ADDR_W-1:0] stat_addr,
  output logic [1:0]        stat_size,
  output logic              stat_write,
  output logic              stat_master,
  output logic [1:0]        stat_cause,
  output logic              stat_overrun
);
  localparam int N_MST = 2;
  localparam int MID_W = 1;

  logic [N_MST-1:0]  m_valid;
  logic [ADDR_W-1:0] m_addr  [N_MST];
  logic [1:0]        m_size  [N_MST];
  logic              m_write [N_MST];
  logic [N_MST-1:0]  gnt;
  logic [MID_W-1:0]  gnt_id;
  logic [N_SLV-1:0]  dec_sel;
  ab_cause_e         dec_cause;
  logic              any_req, bad, accept;

  assign m_valid    = {dma_valid, cpu_valid};
  assign m_addr[0]  = cpu_addr;
  assign m_addr[1]  = dma_addr;
  assign m_size[0]  = cpu_size;
  assign m_size[1]  = dma_size;
  assign m_write[0] = cpu_write;
  assign m_write[1] = dma_write;

  bad_arbiter #(.N_MST(N_MST)) u_arb (
    .req(m_valid), .gnt(gnt), .gnt_id(gnt_id)
  );

  bad_decode #(.ADDR_W(ADDR_W), .AREA_BITS(AREA_BITS), .PERIPH_BITS(PERIPH_BITS)) u_dec (
    .addr(m_addr[gnt_id]), .size(m_size[gnt_id]), .remap(remap_on),
    .sel(dec_sel), .cause(dec_cause)
  );

  assign any_req    = |m_valid;
  assign bad        = any_req && (dec_cause != CAUSE_NONE);
  assign accept     = bad || slv_ready;
  assign slv_valid  = any_req && !bad;
  assign slv_sel    = any_req ? dec_sel : '0;
  assign slv_addr   = m_addr[gnt_id];
  assign slv_size   = m_size[gnt_id];
  assign slv_write  = m_write[gnt_id];
  assign slv_master = gnt_id;
  assign cpu_ready  = gnt[0] && accept;
  assign dma_ready  = gnt[1] && accept;
  assign cpu_abort  = gnt[0] && bad;
  assign dma_abort  = gnt[1] && bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remap_on <= 1'b0;
    else        remap_on <= remap_on ^ remap_cmd;
  end

  bad_abort_status #(.ADDR_W(ADDR_W), .MID_W(MID_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .ab_evt(bad),
    .ev_addr(m_addr[gnt_id]), .ev_size(m_size[gnt_id]), .ev_write(m_write[gnt_id]),
    .ev_mid(gnt_id), .ev_cause(dec_cause), .rd_clr(stat_rd),
    .st_valid(stat_valid), .st_addr(stat_addr), .st_size(stat_size),
    .st_write(stat_write), .st_mid(stat_master), .st_cause(stat_cause),
    .st_overrun(stat_overrun)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    slv_valid |-> $onehot(slv_sel)); // R1
  AST_HALF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    slv_valid && slv_size == SZ_HALF |-> !slv_addr[0]); // R4
  AST_ABORT_NO_SLAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_abort || dma_abort) |-> !slv_valid && $onehot0({cpu_abort, dma_abort})); // R6
  AST_CPU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> !dma_ready && !dma_abort); // R7
  AST_REMAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    remap_cmd |=> remap_on != $past(remap_on)); // R3
endmodule

// File: tb/bus_addr_decoder_test.sv
module bus_addr_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0, dma_valid = 0, dma_write = 0;
  logic [31:0] cpu_addr = 0, dma_addr = 0;
  logic [1:0] cpu_size = 0, dma_size = 0;
  logic slv_ready = 1, remap_cmd = 0, stat_rd = 0;
  logic cpu_ready, cpu_abort, dma_ready, dma_abort, slv_valid, slv_write, slv_master;
  logic [2:0] slv_sel;
  logic [31:0] slv_addr, stat_addr;
  logic [1:0] slv_size, stat_size, stat_cause;
  logic remap_on, stat_valid, stat_write, stat_master, stat_overrun;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_addr_decoder uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cpu_req(input logic [31:0] a, input logic [1:0] s, input logic w);
    @(negedge clk);
    cpu_valid = 1; cpu_addr = a; cpu_size = s; cpu_write = w;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_valid = 0; dma_valid = 0; remap_cmd = 0; stat_rd = 0;
    #1;
  endtask

  task automatic t_reset();
    chk("R11 remap_on", remap_on, 0);
    chk("R11 stat_valid", stat_valid, 0);
    chk("R11 stat_overrun", stat_overrun, 0);
  endtask

  task automatic t_map();
    slv_ready = 1;
    cpu_req(32'h0010_0004, 2, 0);
    chk("R1 flash sel", slv_sel, 3'b001);
    chk("R8 slv_valid", slv_valid, 1);
    chk("R8 slv_addr", slv_addr, 32'h0010_0004);
    chk("R8 cpu_ready", cpu_ready, 1);
    cpu_req(32'h0020_0010, 1, 1);
    chk("R1 sram sel", slv_sel, 3'b010);
    chk("R8 slv_write", slv_write, 1);
    chk("R8 slv_size", slv_size, 1);
    cpu_req(32'hF000_1000, 2, 0);
    chk("R1 periph sel", slv_sel, 3'b100);
    slv_ready = 0; #1;
    chk("R8 backpressure ready", cpu_ready, 0);
    chk("R8 backpressure valid", slv_valid, 1);
    slv_ready = 1;
    idle();
  endtask

  task automatic t_boot();
    cpu_req(32'h0000_0000, 2, 0);
    chk("R2 boot flash", slv_sel, 3'b001);
    idle();
    @(negedge clk); remap_cmd = 1;
    idle();
    chk("R3 remap on", remap_on, 1);
    cpu_req(32'h0000_0100, 2, 0);
    chk("R2 boot sram", slv_sel, 3'b010);
    cpu_req(32'h0010_0000, 2, 0);
    chk("R2 flash area unaffected", slv_sel, 3'b001);
    idle();
    @(negedge clk); remap_cmd = 1;
    idle();
    chk("R3 remap off", remap_on, 0);
    cpu_req(32'h0000_0000, 2, 0);
    chk("R2 boot flash again", slv_sel, 3'b001);
    idle();
  endtask

  task automatic t_align();
    cpu_req(32'h0010_0001, 1, 0);
    chk("R4 half odd abort", cpu_abort, 1);
    chk("R6 abort ready", cpu_ready, 1);
    chk("R6 abort no slave", slv_valid, 0);
    cpu_req(32'h0010_0001, 0, 0);
    chk("R4 byte odd ok", slv_valid, 1);
    cpu_req(32'h0010_0002, 2, 0);
    chk("R4 word +2 abort", cpu_abort, 1);
    cpu_req(32'h0010_0002, 1, 0);
    chk("R4 half +2 ok", slv_valid, 1);
    cpu_req(32'h0010_0004, 3, 0);
    chk("R4 size3 aligned ok", slv_valid, 1);
    cpu_req(32'h0030_0000, 2, 0);
    chk("R5 undefined abort", cpu_abort, 1);
    idle();
  endtask

  task automatic t_prio();
    @(negedge clk);
    cpu_valid = 1; cpu_addr = 32'h0020_0000; cpu_size = 2;
    dma_valid = 1; dma_addr = 32'h0010_0008; dma_size = 2; dma_write = 1;
    #1;
    chk("R7 cpu wins", slv_master, 0);
    chk("R7 dma stalled", dma_ready, 0);
    @(negedge clk); cpu_valid = 0; #1;
    chk("R7 dma granted", slv_master, 1);
    chk("R7 dma ready", dma_ready, 1);
    chk("R8 dma addr forwarded", slv_addr, 32'h0010_0008);
    idle();
  endtask

  task automatic t_status();
    @(negedge clk); stat_rd = 1;
    idle();
    chk("R10 cleared", stat_valid, 0);
    @(negedge clk);
    dma_valid = 1; dma_addr = 32'h0020_0003; dma_size = 1; dma_write = 1;
    #1;
    chk("R6 dma abort", dma_abort, 1);
    idle();
    chk("R9 valid", stat_valid, 1);
    chk("R9 addr", stat_addr, 32'h0020_0003);
    chk("R9 size", stat_size, 1);
    chk("R9 write", stat_write, 1);
    chk("R9 master", stat_master, 1);
    chk("R5 cause misalign", stat_cause, 1);
    chk("R10 no overrun yet", stat_overrun, 0);
    cpu_req(32'h1000_0001, 1, 0);
    idle();
    chk("R10 overrun set", stat_overrun, 1);
    chk("R10 first kept", stat_addr, 32'h0020_0003);
    @(negedge clk); stat_rd = 1;
    idle();
    chk("R10 read clears valid", stat_valid, 0);
    chk("R10 read clears overrun", stat_overrun, 0);
    cpu_req(32'h0020_0001, 2, 0);
    idle();
    @(negedge clk);
    stat_rd = 1; cpu_valid = 1; cpu_addr = 32'h1000_0001; cpu_size = 1; cpu_write = 0;
    idle();
    chk("R10 read+abort captures", stat_addr, 32'h1000_0001);
    chk("R5 undef beats misalign", stat_cause, 2);
    chk("R10 read+abort no overrun", stat_overrun, 0);
    chk("R9 master cpu", stat_master, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    t_reset();
    t_map();
    t_boot();
    t_align();
    t_prio();
    t_status();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule